// File: doc/BRIEF.md
# Command-Framed Serial Register Port

This block is a serial slave port for a mixed-signal converter controller. A host drives a chip select, a serial clock and a data line. Each frame opens with a command byte, and that byte alone decides how many data bytes follow (none, one or two) and which register the frame writes. The registers are conversion control, setup (with optional unipolar and bipolar companion registers), averaging, the DAC interface word, and the optional GPIO direction and output registers. When a write frame is complete, the captured value lands in its register and a single-cycle strobe tells the rest of the chip which register changed.

Serial inputs are brought into the system clock domain by two-flop synchronizers, and edges are detected there. The system clock must run at least four times faster than the serial clock. A GPIO read command shifts a status byte out on the data output. The serial clock edge that moves that output is chosen by the clock-mode field of the setup register. The `HAS_GPIO` parameter removes the GPIO registers. A build without them still accepts GPIO command frames of the normal length but acts on none of them.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset every register output is 0, `wr_stb` is 0 and `dout` is 0.
- R2: A frame runs while `cs_n` is low. `din` is sampled on falling `sclk` edges, and the first 8 bits form the command byte, MSB first. `sclk` edges while `cs_n` is high have no effect.
- R3: Command `1ccccccc` is an 8-bit frame that loads `conv_reg` with its low 7 bits (`wr_sel` = 1).
- R4: Command `01kkrrmm` loads `setup_reg` with its low 6 bits (`wr_sel` = 2). With mm = 01, one more byte follows and loads `unip_reg`. With mm = 10, one more byte follows and loads `bip_reg`. Otherwise the frame is 8 bits long.
- R5: Command `0010aaaa` is an 8-bit frame that loads `avg_reg` with its low 4 bits (`wr_sel` = 3).
- R6: Command `0001xxxx` takes two data bytes, and `dac_reg` becomes {first byte, second byte} (`wr_sel` = 4). The low 4 command bits do not matter.
- R7: Command `00001xxx` loads `gpio_dir` with the low 4 bits of one data byte (`wr_sel` = 5). Command `000001xx` does the same for `gpio_out` (`wr_sel` = 6).
- R8: Command `0000001x` is a 16-bit read frame that shifts {`gpio_out`, `gpio_in`} out on `dout`, MSB first. It writes nothing, and `dout` is 0 outside a read.
- R9: With setup bits [5:4] other than 11, `dout` shows read bit 7 after the 8th falling `sclk` edge and shifts on each later falling edge. With bits [5:4] = 11, bit 7 appears on the first rising edge after the 8th falling edge, and the data shifts on each later rising edge.
- R10: With `HAS_GPIO` = 0, GPIO commands keep their frame length but change no register, raise no strobe and leave `dout` at 0.
- R11: A frame cut short by `cs_n` rising changes no register and raises no strobe. The next frame decodes a fresh command.
- R12: Each complete write frame raises `wr_stb` for exactly one cycle, with its `wr_sel` code. Bits sent after the frame is complete are ignored until `cs_n` rises. Commands `0000000x` write nothing.
- R13: The port works the same with `sclk` idling low or idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| gpio_in | input | 4 | GPIO pin levels returned by a read |
| conv_reg | output | 7 | Conversion control register |
| setup_reg | output | 6 | Setup register; bits [5:4] are the clock mode |
| unip_reg | output | 8 | Unipolar-mode register |
| bip_reg | output | 8 | Bipolar-mode register |
| avg_reg | output | 4 | Averaging register |
| dac_reg | output | 16 | DAC interface word |
| gpio_dir | output | 4 | GPIO direction register |
| gpio_out | output | 4 | GPIO output register |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_sel | output | 3 | Code of the register last written |

## Verification
The bench builds two copies that share the same serial inputs: one with `HAS_GPIO` = 1 and one with `HAS_GPIO` = 0. Every frame therefore shows a populated GPIO decode and a stripped one side by side. This makes it possible to check that GPIO commands in the stripped copy consume their bytes, stay silent on the strobe and keep `dout` at 0, while the other copy updates its registers. Reads run in both clock-mode settings and with both `sclk` idle levels, so each update edge is checked against each bit order.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int CMD_W    = 8;
  localparam int GPIO_W   = 4;
  localparam int CONV_W   = 7;
  localparam int SETUP_W  = 6;
  localparam int AVG_W    = 4;
  localparam int DAC_W    = 16;
  localparam int MAX_BITS = 24;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_CONV  = 3'd1,
    TGT_SETUP = 3'd2,
    TGT_AVG   = 3'd3,
    TGT_DAC   = 3'd4,
    TGT_GDIR  = 3'd5,
    TGT_GOUT  = 3'd6,
    TGT_GRD   = 3'd7
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] nbytes;
  } cmd_info_t;

  // Leading-one style decode of the command byte.
  function automatic cmd_info_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_info_t r;
    casez (c)
      8'b1???????: r = '{TGT_CONV, 2'd0};
      8'b01??????: r = '{TGT_SETUP, (c[1] ^ c[0]) ? 2'd1 : 2'd0};
      8'b0010????: r = '{TGT_AVG, 2'd0};
      8'b0001????: r = '{TGT_DAC, 2'd2};
      8'b00001???: r = '{TGT_GDIR, 2'd1};
      8'b000001??: r = '{TGT_GOUT, 2'd1};
      8'b0000001?: r = '{TGT_GRD, 2'd1};
      default:     r = '{TGT_NONE, 2'd0};
    endcase
    return r;
  endfunction

  function automatic logic is_gpio(input tgt_e t);
    return (t == TGT_GDIR) || (t == TGT_GOUT) || (t == TGT_GRD);
  endfunction

  // Total frame length in bits for a given data byte count.
  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] nb);
    return CNT_W'({nb, 3'b000}) + CNT_W'(CMD_W);
  endfunction
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_fe_pkg::*;
#(
  parameter bit HAS_GPIO = 1'b1
) (
  input  logic [CMD_W-1:0] cmd,
  output tgt_e             tgt,
  output logic [CNT_W-1:0] nbits,
  output logic             wr_en,
  output logic             rd_en
);
  cmd_info_t info;
  logic      allowed;

  always_comb begin
    info    = decode_cmd(cmd);
    allowed = HAS_GPIO || !is_gpio(info.tgt);
    tgt     = info.tgt;
    nbits   = frame_bits(info.nbytes);
    wr_en   = allowed && (info.tgt != TGT_NONE) && (info.tgt != TGT_GRD);
    rd_en   = allowed && (info.tgt == TGT_GRD);
  end
endmodule

// File: rtl/spi_dout_shift.sv
module spi_dout_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              rise_mode,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              dout
);
  logic [BYTE_W-1:0] sr;
  logic              armed, loaded;
  logic              shift_edge;

  assign shift_edge = rise_mode ? sclk_rise : sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      armed  <= 1'b0;
      loaded <= 1'b0;
    end else if (clr) begin
      sr     <= '0;
      armed  <= 1'b0;
      loaded <= 1'b0;
    end else if (arm && !rise_mode) begin
      sr     <= rd_byte;
      loaded <= 1'b1;
    end else if (arm) begin
      armed  <= 1'b1;
    end else if (armed && sclk_rise) begin
      sr     <= rd_byte;
      loaded <= 1'b1;
      armed  <= 1'b0;
    end else if (loaded && shift_edge) begin
      sr     <= {sr[BYTE_W-2:0], 1'b0};
    end
  end

  assign dout = sr[BYTE_W-1];
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter bit HAS_GPIO = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  output logic               dout,
  input  logic [GPIO_W-1:0]  gpio_in,
  output logic [CONV_W-1:0]  conv_reg,
  output logic [SETUP_W-1:0] setup_reg,
  output logic [7:0]         unip_reg,
  output logic [7:0]         bip_reg,
  output logic [AVG_W-1:0]   avg_reg,
  output logic [DAC_W-1:0]   dac_reg,
  output logic [GPIO_W-1:0]  gpio_dir,
  output logic [GPIO_W-1:0]  gpio_out,
  output logic               wr_stb,
  output logic [2:0]         wr_sel
);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BITS);
  localparam int               DAT_W    = MAX_BITS - CMD_W;

  // Synchronized serial inputs and detected edges.
  logic [2:0] sync_q;
  logic       cs_s, sclk_s, din_s, sclk_d;
  logic       sclk_rise, sclk_fall, cs_act;

  spi_sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(sync_q)
  );
  assign {cs_s, sclk_s, din_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_act    = ~cs_s;

  // Frame state.
  logic [CNT_W-1:0] bit_cnt;
  logic [CMD_W-2:0] cmd_sh;
  logic [CMD_W-1:0] cmd_q;
  logic [DAT_W-1:0] dat_sh;
  logic             cmd_ok, cmd_new, done;

  tgt_e             cur_tgt;
  logic [CNT_W-1:0] cur_bits;
  logic             cur_wr, cur_rd, commit;

  spi_cmd_decode #(.HAS_GPIO(HAS_GPIO)) u_dec (
    .cmd(cmd_q), .tgt(cur_tgt), .nbits(cur_bits), .wr_en(cur_wr), .rd_en(cur_rd)
  );

  assign commit = cs_act && cmd_ok && !done && cur_wr && (bit_cnt == cur_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cmd_sh  <= '0;
      cmd_q   <= '0;
      dat_sh  <= '0;
      cmd_ok  <= 1'b0;
      cmd_new <= 1'b0;
      done    <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      cmd_ok  <= 1'b0;
      cmd_new <= 1'b0;
      done    <= 1'b0;
    end else begin
      cmd_new <= 1'b0;
      if (commit) done <= 1'b1;
      if (sclk_fall && !done) begin
        if (bit_cnt < CNT_CMD) begin
          cmd_sh <= {cmd_sh[CMD_W-3:0], din_s};
          if (bit_cnt == CNT_LAST) begin
            cmd_q   <= {cmd_sh, din_s};
            cmd_ok  <= 1'b1;
            cmd_new <= 1'b1;
          end
        end else begin
          dat_sh <= {dat_sh[DAT_W-2:0], din_s};
        end
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end

  // Register file outside the GPIO group.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_reg  <= '0;
      setup_reg <= '0;
      unip_reg  <= '0;
      bip_reg   <= '0;
      avg_reg   <= '0;
      dac_reg   <= '0;
      wr_stb    <= 1'b0;
      wr_sel    <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        wr_sel <= cur_tgt;
        case (cur_tgt)
          TGT_CONV: conv_reg <= cmd_q[CONV_W-1:0];
          TGT_SETUP: begin
            setup_reg <= cmd_q[SETUP_W-1:0];
            if (cmd_q[1:0] == 2'b01) unip_reg <= dat_sh[7:0];
            if (cmd_q[1:0] == 2'b10) bip_reg  <= dat_sh[7:0];
          end
          TGT_AVG: avg_reg <= cmd_q[AVG_W-1:0];
          TGT_DAC: dac_reg <= dat_sh[DAC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // GPIO group exists only when the parameter asks for it.
  if (HAS_GPIO) begin : g_gpio
    logic [GPIO_W-1:0] dir_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= '0;
        out_q <= '0;
      end else if (commit) begin
        if (cur_tgt == TGT_GDIR) dir_q <= dat_sh[GPIO_W-1:0];
        if (cur_tgt == TGT_GOUT) out_q <= dat_sh[GPIO_W-1:0];
      end
    end
    assign gpio_dir = dir_q;
    assign gpio_out = out_q;
  end else begin : g_nogpio
    assign gpio_dir = '0;
    assign gpio_out = '0;
  end

  // Read-back shifter; clock mode 11 selects the rising edge.
  logic rd_arm, rise_mode;
  assign rd_arm    = cmd_new && cur_rd;
  assign rise_mode = (setup_reg[5:4] == 2'b11);

  spi_dout_shift #(.BYTE_W(2 * GPIO_W)) u_dout (
    .clk(clk), .rst_n(rst_n), .clr(!cs_act), .arm(rd_arm),
    .rise_mode(rise_mode), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .rd_byte({gpio_out, gpio_in}), .dout(dout)
  );
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
  import spi_fe_pkg::*;
#(
  parameter bit HAS_GPIO = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             commit,
  input logic             wr_stb,
  input logic [2:0]       wr_sel,
  input logic [DAC_W-1:0] dac_reg,
  input logic             dout,
  input logic [CNT_W-1:0] bit_cnt
);
  // R12: the strobe lasts a single cycle
  assert_stb_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R12: a completed frame is followed by the strobe
  assert_commit_stb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wr_stb);

  // R11: with select released no strobe can follow
  assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_act) |-> !wr_stb);

  // R2: deselect clears the bit counter
  assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));

  // R6: the DAC word moves only together with the strobe
  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(dac_reg));

  // R10: no GPIO strobe code in a build without GPIOs
  assert_no_gpio_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (HAS_GPIO || (wr_sel != 3'd5 && wr_sel != 3'd6)));

  // R8: output is low once select is released
  assert_idle_dout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !dout);
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.HAS_GPIO(HAS_GPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .commit(commit), .wr_stb(wr_stb),
  .wr_sel(wr_sel), .dac_reg(dac_reg), .dout(dout), .bit_cnt(bit_cnt)
);

// File: tb/spi_cmd_frontend_bench.sv
`timescale 1ns/1ps
module spi_cmd_frontend_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [3:0] gpio_in = 4'h0;

  logic dout_g, dout_n, stb_g_w, stb_n_w;
  logic [6:0] conv_g, conv_n;
  logic [5:0] setup_g, setup_n;
  logic [7:0] unip_g, unip_n, bip_g, bip_n;
  logic [3:0] avg_g, avg_n, gdir_g, gdir_n, gout_g, gout_n;
  logic [15:0] dac_g, dac_n;
  logic [2:0] sel_g_w, sel_n_w;

  spi_cmd_frontend #(.HAS_GPIO(1'b1)) u_spi_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout_g),
    .gpio_in(gpio_in), .conv_reg(conv_g), .setup_reg(setup_g), .unip_reg(unip_g),
    .bip_reg(bip_g), .avg_reg(avg_g), .dac_reg(dac_g), .gpio_dir(gdir_g),
    .gpio_out(gout_g), .wr_stb(stb_g_w), .wr_sel(sel_g_w));

  spi_cmd_frontend #(.HAS_GPIO(1'b0)) u_spi_cmd_frontend_nogpio (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout_n),
    .gpio_in(gpio_in), .conv_reg(conv_n), .setup_reg(setup_n), .unip_reg(unip_n),
    .bip_reg(bip_n), .avg_reg(avg_n), .dac_reg(dac_n), .gpio_dir(gdir_n),
    .gpio_out(gout_n), .wr_stb(stb_n_w), .wr_sel(sel_n_w));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int stb_g = 0, stb_n = 0, ng_bad = 0, rd_bad = 0, nf = 0;
  logic [2:0] sel_g = '0, sel_n = '0;
  bit rd_chk = 0, rmode = 0, m_loaded = 0, m_armed = 0;
  logic [7:0] rd_exp = '0, m_sh = '0;

  logic [6:0] e_conv = '0;
  logic [5:0] e_setup = '0;
  logic [7:0] e_unip = '0, e_bip = '0;
  logic [3:0] e_avg = '0, e_gdir = '0, e_gout = '0;
  logic [15:0] e_dac = '0;

  always @(negedge clk) begin
    if (stb_g_w) begin stb_g++; sel_g = sel_g_w; end
    if (stb_n_w) begin stb_n++; sel_n = sel_n_w; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one SCLK edge, checking DOUT just before it against the bench model.
  task automatic sedge(input logic v);
    if (rd_chk && m_loaded && dout_g !== m_sh[7]) rd_bad++;
    if (dout_n !== 1'b0) ng_bad++;
    sclk = v;
    if (!v) begin
      nf++;
      if (nf == 8 && !rmode) begin m_sh = rd_exp; m_loaded = 1; end
      else if (nf == 8) m_armed = 1;
      else if (!rmode && m_loaded) m_sh = {m_sh[6:0], 1'b0};
    end else if (rmode) begin
      if (m_armed) begin m_sh = rd_exp; m_loaded = 1; m_armed = 0; end
      else if (m_loaded) m_sh = {m_sh[6:0], 1'b0};
    end
  endtask

  task automatic xfer(input logic [23:0] bits, input int nbits, input bit idle_hi);
    @(negedge clk);
    nf = 0; m_loaded = 0; m_armed = 0;
    sclk = idle_hi;
    #40 cs_n = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      #20 din = bits[23-i];
      #20;
      if (idle_hi) begin sedge(1'b0); #40; sedge(1'b1); end
      else         begin sedge(1'b1); #40; sedge(1'b0); end
    end
    #40 cs_n = 1'b1;
    din = 1'b0;
    #200;
  endtask

  task automatic check_regs(input string req);
    chk({conv_g, setup_g, unip_g, bip_g, avg_g, dac_g, gdir_g, gout_g} ===
        {e_conv, e_setup, e_unip, e_bip, e_avg, e_dac, e_gdir, e_gout}, req,
        {conv_g, setup_g, unip_g, bip_g}, {e_conv, e_setup, e_unip, e_bip});
    chk({conv_n, setup_n, unip_n, bip_n, avg_n, dac_n, gdir_n, gout_n} ===
        {e_conv, e_setup, e_unip, e_bip, e_avg, e_dac, 8'h00}, {req, " nogpio"},
        {avg_n, dac_n, gdir_n, gout_n}, {e_avg, e_dac, 8'h00});
  endtask

  // Write frame: expected registers are set by the caller beforehand.
  task automatic wr_frame(input string req, input logic [7:0] cmd, input logic [15:0] data,
                          input int nbits, input bit idle_hi, input int eg, input int en);
    int g0, n0;
    g0 = stb_g; n0 = stb_n;
    xfer({cmd, data}, nbits, idle_hi);
    chk(stb_g - g0 == (eg != 0 ? 1 : 0), {req, " strobe count"}, stb_g - g0, eg != 0);
    chk(stb_n - n0 == (en != 0 ? 1 : 0), {req, " strobe count nogpio"}, stb_n - n0, en != 0);
    if (eg != 0) chk(sel_g == 3'(eg), {req, " wr_sel"}, sel_g, eg);
    if (en != 0) chk(sel_n == 3'(en), {req, " wr_sel nogpio"}, sel_n, en);
    check_regs(req);
  endtask

  task automatic rd_frame(input string req, input bit idle_hi, input logic [7:0] exp);
    int g0, n0;
    g0 = stb_g; n0 = stb_n;
    rd_chk = 1; rmode = (e_setup[5:4] == 2'b11); rd_exp = exp; rd_bad = 0;
    xfer({8'h02, 8'hA7, 8'h00}, 16, idle_hi);
    rd_chk = 0;
    chk(rd_bad == 0, {req, " read bits"}, rd_bad, 0);
    chk(stb_g == g0 && stb_n == n0, {req, " read writes nothing"}, stb_g - g0 + stb_n - n0, 0);
  endtask

  task automatic t_reset;
    chk({dout_g, dout_n, stb_g_w, stb_n_w} === 4'b0, "R1 idle outputs", {dout_g, dout_n, stb_g_w, stb_n_w}, 0);
    check_regs("R1 reset registers");
  endtask

  task automatic t_cs_high_ignored;
    @(negedge clk);
    din = 1'b1;
    for (int i = 0; i < 6; i++) begin #40 sclk = 1'b1; #40 sclk = 1'b0; end
    din = 1'b0;
    #200;
    chk(stb_g == 0 && stb_n == 0, "R2 edges with cs high", stb_g + stb_n, 0);
    e_conv = 7'h0A;
    wr_frame("R2 R3 conv idle low", 8'h8A, 16'h0, 8, 0, 1, 1);
  endtask

  task automatic t_basic_writes;
    e_conv = 7'h25;
    wr_frame("R3 R13 conv idle high", 8'hA5, 16'h0, 8, 1, 1, 1);
    e_avg = 4'hB;
    wr_frame("R5 avg", 8'h2B, 16'h0, 8, 0, 3, 3);
    e_setup = 6'h1C;
    wr_frame("R4 setup only", 8'h5C, 16'h0, 8, 0, 2, 2);
    e_setup = 6'h01; e_unip = 8'h3C;
    wr_frame("R4 setup plus unipolar", 8'h41, 16'h3C00, 16, 0, 2, 2);
    e_setup = 6'h02; e_bip = 8'hC3;
    wr_frame("R4 R13 setup plus bipolar", 8'h42, 16'hC300, 16, 1, 2, 2);
  endtask

  task automatic t_dac;
    e_dac = 16'hBEEF;
    wr_frame("R6 dac", 8'h1F, 16'hBEEF, 24, 0, 4, 4);
    e_dac = 16'h1234;
    wr_frame("R6 R13 dac low nibble differs", 8'h13, 16'h1234, 24, 1, 4, 4);
  endtask

  task automatic t_gpio;
    e_gdir = 4'hA;
    wr_frame("R7 R10 gpio dir", 8'h08, 16'hFA00, 16, 0, 5, 0);
    e_gout = 4'h5;
    wr_frame("R7 R10 gpio out", 8'h07, 16'h3500, 16, 0, 6, 0);
  endtask

  task automatic t_reads;
    gpio_in = 4'h9;
    rd_frame("R8 R9 fall mode idle low", 0, 8'h59);
    gpio_in = 4'hC;
    rd_frame("R8 R9 R13 fall mode idle high", 1, 8'h5C);
    e_setup = 6'h30;
    wr_frame("R4 R9 clock mode 11", 8'h70, 16'h0, 8, 0, 2, 2);
    gpio_in = 4'h6;
    rd_frame("R9 rise mode idle low", 0, 8'h56);
    gpio_in = 4'h3;
    rd_frame("R9 R13 rise mode idle high", 1, 8'h53);
    chk(ng_bad == 0, "R10 nogpio dout stays low", ng_bad, 0);
  endtask

  task automatic t_abort;
    int g0;
    g0 = stb_g;
    xfer(24'h10_FFF0, 20, 0);
    xfer(24'h41_F000, 12, 1);
    chk(stb_g == g0, "R11 aborted frames strobe", stb_g - g0, 0);
    check_regs("R11 aborted frames registers");
    e_conv = 7'h19;
    wr_frame("R11 fresh decode after abort", 8'h99, 16'h0, 8, 0, 1, 1);
  endtask

  task automatic t_trailing;
    e_conv = 7'h01;
    wr_frame("R12 trailing bits ignored", 8'h81, 16'hFF00, 16, 0, 1, 1);
    wr_frame("R12 no-op command", 8'h00, 16'h0, 8, 0, 0, 0);
    wr_frame("R12 no-op with trailing byte", 8'h01, 16'hFF00, 16, 1, 0, 0);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_cs_high_ignored();
    t_basic_writes();
    t_dac();
    t_gpio();
    t_reads();
    t_abort();
    t_trailing();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule